// File: doc/BRIEF.md
# Time-of-Day Clock with Shadow Access and Frequency Trim

The block keeps a free-running IEEE 1588 time of day as a 48-bit seconds count and a 30-bit nanoseconds count. Every clock cycle the nanoseconds advance by a fixed nominal amount (`NS_PER_CYCLE`). When the nanoseconds pass one second they wrap, and the seconds carry in the same cycle. The live time is also driven out on dedicated ports for timestamping logic elsewhere in the chip.

Software reaches the clock through a small synchronous write/read bus. It never writes the live time directly. Instead it fills a shadow set (seconds upper word, seconds lower word, nanoseconds) and then writes an action code. The action can copy the live time into the shadow set, copy the shadow set into the live time, or step the live time by a signed nanosecond amount. The usual sequence is IDLE first, then the shadow fill, then LOAD or DELTA.

A frequency trim speeds the clock up or slows it down without a step. It does this by adding or removing one nanosecond each time a programmed interval has elapsed. The interval is counted in picoseconds or in nanoseconds, selected by a unit bit.

Top module: `tod_clock`

## Requirements
- R1: While rst_ni is low, the live seconds and nanoseconds outputs are 0 and every register address reads 0.
- R2: With no action and trim disabled, the live nanoseconds increase by NS_PER_CYCLE (8 in the bench) at every rising clock edge.
- R3: Nanoseconds never reach 1,000,000,000. A sum at or above that value has 1,000,000,000 subtracted, and the 48-bit seconds increment at the same edge, including the carry from bit 31 into bit 32.
- R4: The register map is as follows; each address reads back its stored value, and unused bits read 0.
  - Address 0: action, bits [1:0].
  - Address 1: shadow seconds, bits [47:32] in data bits [15:0].
  - Address 2: shadow seconds, bits [31:0].
  - Address 3: shadow nanoseconds, 32 bits.
  - Address 4: trim interval in bits [29:0], plus a unit bit in bit 30 (1 = nanoseconds, 0 = picoseconds).
  - Address 5: trim enable in bit 0, plus a direction bit in bit 1 (1 = slow down, 0 = speed up).
- R5: Action codes are 0 IDLE, 1 SAVE, 2 LOAD and 3 DELTA, and each takes effect at the edge of its write. IDLE and all shadow or trim register writes leave the live time running at its normal rate.
- R6: SAVE copies the live time present in the write cycle into the shadow seconds and shadow nanoseconds.
- R7: LOAD makes the live time equal to the shadow value right after the write edge, with no increment added in that cycle.
- R8: LOAD treats shadow nanoseconds in the range 0x3FFFFFF0 to 0x3FFFFFFF as a negative value. It loads shadow seconds minus 1 and nanoseconds 999,999,984 plus the low 4 bits. Any other shadow nanoseconds value of 1,000,000,000 or more loads as 999,999,999.
- R9: DELTA sets the live time to its previous value plus the cycle increment plus the shadow nanoseconds read as a 32-bit two's complement amount. That amount is first saturated to ±499,999,999, and any result outside one second borrows from or carries into the seconds.
- R10: With the trim enabled and a nonzero interval, an accumulator gains NS_PER_CYCLE each cycle (×1000 in picosecond unit). In every cycle where it reaches the interval, that cycle's increment changes by exactly 1 ns in the programmed direction and the interval is subtracted. If the interval is not larger than the per-cycle step, the change happens every cycle. Writing address 4 or 5 clears the accumulator.
- R11: With the trim enable bit at 0, no nanosecond is ever added or removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one register write per cycle |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| tod_sec_o | output | 48 | Live seconds |
| tod_ns_o | output | 30 | Live nanoseconds |

## Verification
Register reads are combinational, so the bench samples read data 1 ns after setting the address, with no clock edge in between. Actions and free running show up on the live outputs after exactly one edge. The bench drives every write at a falling edge, records the live time at that moment, and compares the live time at the next falling edge against that record plus the expected step. The trim is checked over windows of 50 edges. With the accumulator cleared at enable, any such window holds a fixed count of trim cycles, so the expected total is exact whatever the window's phase.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int SEC_W      = 48;
  localparam int NS_W       = 30;
  localparam int IVL_W      = 30;
  localparam int NS_PER_SEC = 1_000_000_000;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SAVE  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DELTA = 2'd3
  } act_e;

  localparam logic [ADDR_W-1:0] A_ACT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SHI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SNS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TIVL = 3'd4;
  localparam logic [ADDR_W-1:0] A_TCTL = 3'd5;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  tod_t              live_i,
  output logic [SEC_W-1:0]  sh_sec_o,
  output logic [DATA_W-1:0] sh_ns_o,
  output logic              do_load_o,
  output logic              do_delta_o,
  output logic [IVL_W-1:0]  trim_ivl_o,
  output logic              trim_unit_o,
  output logic              trim_en_o,
  output logic              trim_dir_o,
  output logic              trim_clr_o
);
  localparam int HI_W = SEC_W - DATA_W;

  act_e              act_q;
  logic [SEC_W-1:0]  sh_sec_q;
  logic [DATA_W-1:0] sh_ns_q;
  logic [IVL_W-1:0]  ivl_q;
  logic              unit_q, en_q, dir_q;
  logic              act_wr, do_save;

  assign act_wr     = we_i && (addr_i == A_ACT);
  assign do_save    = act_wr && (wdata_i[1:0] == ACT_SAVE);
  assign do_load_o  = act_wr && (wdata_i[1:0] == ACT_LOAD);
  assign do_delta_o = act_wr && (wdata_i[1:0] == ACT_DELTA);
  assign trim_clr_o = we_i && ((addr_i == A_TIVL) || (addr_i == A_TCTL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= ACT_IDLE;
      sh_sec_q <= '0;
      sh_ns_q  <= '0;
      ivl_q    <= '0;
      unit_q   <= 1'b0;
      en_q     <= 1'b0;
      dir_q    <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_ACT: begin
          act_q <= act_e'(wdata_i[1:0]);
          if (do_save) begin
            sh_sec_q <= live_i.sec;
            sh_ns_q  <= {{(DATA_W-NS_W){1'b0}}, live_i.ns};
          end
        end
        A_SHI:  sh_sec_q[SEC_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        A_SLO:  sh_sec_q[DATA_W-1:0]     <= wdata_i;
        A_SNS:  sh_ns_q                  <= wdata_i;
        A_TIVL: begin
          ivl_q  <= wdata_i[IVL_W-1:0];
          unit_q <= wdata_i[IVL_W];
        end
        A_TCTL: begin
          en_q  <= wdata_i[0];
          dir_q <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_ACT:  rdata_o = {{(DATA_W-2){1'b0}}, act_q};
      A_SHI:  rdata_o = {{(DATA_W-HI_W){1'b0}}, sh_sec_q[SEC_W-1:DATA_W]};
      A_SLO:  rdata_o = sh_sec_q[DATA_W-1:0];
      A_SNS:  rdata_o = sh_ns_q;
      A_TIVL: rdata_o = {{(DATA_W-IVL_W-1){1'b0}}, unit_q, ivl_q};
      A_TCTL: rdata_o = {{(DATA_W-2){1'b0}}, dir_q, en_q};
      default: rdata_o = '0;
    endcase
  end

  assign sh_sec_o    = sh_sec_q;
  assign sh_ns_o     = sh_ns_q;
  assign trim_ivl_o  = ivl_q;
  assign trim_unit_o = unit_q;
  assign trim_en_o   = en_q;
  assign trim_dir_o  = dir_q;

  // shadow set only moves on a bus write
  p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(sh_ns_q) && $stable(sh_sec_q)));
endmodule

// File: rtl/tod_trim.sv
module tod_trim
  import tod_pkg::*;
#(
  parameter int NS_PER_CYCLE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             unit_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             pulse_o
);
  localparam int ACC_W = 32;
  localparam logic [ACC_W-1:0] STEP_NS = ACC_W'(NS_PER_CYCLE);
  localparam logic [ACC_W-1:0] STEP_PS = ACC_W'(NS_PER_CYCLE * 1000);

  logic [ACC_W-1:0] acc_q, acc_d, step;
  logic [ACC_W:0]   nxt, ivl_x, rem;
  logic             active;

  always_comb begin
    step    = unit_i ? STEP_NS : STEP_PS;
    nxt     = {1'b0, acc_q} + {1'b0, step};
    ivl_x   = {{(ACC_W+1-IVL_W){1'b0}}, ivl_i};
    rem     = nxt - ivl_x;
    active  = en_i && (ivl_i != '0);
    pulse_o = active && (nxt >= ivl_x);
    if (clr_i || !active)  acc_d = '0;
    else if (pulse_o)      acc_d = (rem >= ivl_x) ? '0 : ACC_W'(rem);
    else                   acc_d = ACC_W'(nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  p_acc_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !clr_i) |=> ({1'b0, acc_q} < ivl_x));
  p_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pulse_o);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_PER_CYCLE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              delta_i,
  input  logic [SEC_W-1:0]  sh_sec_i,
  input  logic [DATA_W-1:0] sh_ns_i,
  input  logic              trim_pulse_i,
  input  logic              trim_dir_i,
  output tod_t              tod_o
);
  localparam int SW = 34;
  localparam logic signed [SW-1:0] INC_S = SW'(NS_PER_CYCLE);
  localparam logic signed [SW-1:0] NSPS  = SW'(NS_PER_SEC);
  localparam logic signed [SW-1:0] DMAX  = SW'(NS_PER_SEC / 2 - 1);
  localparam logic [NS_W-1:0] NS_NEG_BASE = NS_W'(NS_PER_SEC - 16);
  localparam logic [NS_W-1:0] NS_TOP      = NS_W'(NS_PER_SEC - 1);

  logic [SEC_W-1:0]       sec_q, sec_d;
  logic [NS_W-1:0]        ns_q, ns_d;
  logic signed [SW-1:0]   inc, dfull, dsat, sum;

  always_comb begin
    inc = INC_S;
    if (trim_pulse_i) inc = trim_dir_i ? INC_S - SW'(1) : INC_S + SW'(1);
    dfull = $signed({{(SW-DATA_W){sh_ns_i[DATA_W-1]}}, sh_ns_i});
    if (dfull > DMAX)       dsat = DMAX;
    else if (dfull < -DMAX) dsat = -DMAX;
    else                    dsat = dfull;
    sum = $signed({{(SW-NS_W){1'b0}}, ns_q}) + inc + (delta_i ? dsat : '0);
    sec_d = sec_q;
    if (sum < 0) begin
      ns_d  = NS_W'(sum + NSPS);
      sec_d = sec_q - SEC_W'(1);
    end else if (sum >= NSPS) begin
      ns_d  = NS_W'(sum - NSPS);
      sec_d = sec_q + SEC_W'(1);
    end else begin
      ns_d  = NS_W'(sum);
    end
    if (load_i) begin
      sec_d = sh_sec_i;
      if (sh_ns_i[DATA_W-1:4] == 28'h3FF_FFFF) begin
        // encoded negative: previous second
        sec_d = sh_sec_i - SEC_W'(1);
        ns_d  = NS_NEG_BASE + {{(NS_W-4){1'b0}}, sh_ns_i[3:0]};
      end else if (sh_ns_i >= DATA_W'(NS_PER_SEC)) begin
        ns_d = NS_TOP;
      end else begin
        ns_d = sh_ns_i[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  assign tod_o.sec = sec_q;
  assign tod_o.ns  = ns_q;

  p_ns_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_q < NS_W'(NS_PER_SEC));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !delta_i && !trim_pulse_i && ns_q < NS_W'(NS_PER_SEC - NS_PER_CYCLE))
    |=> (ns_q == $past(ns_q) + NS_W'(NS_PER_CYCLE)) && $stable(sec_q));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !delta_i && !trim_pulse_i && ns_q >= NS_W'(NS_PER_SEC - NS_PER_CYCLE))
    |=> (sec_q == $past(sec_q) + SEC_W'(1)) &&
        ({2'b0, ns_q} == {2'b0, $past(ns_q)} + 32'(NS_PER_CYCLE) - 32'(NS_PER_SEC)));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sh_ns_i < DATA_W'(NS_PER_SEC))
    |=> (ns_q == $past(sh_ns_i[NS_W-1:0])) && (sec_q == $past(sh_sec_i)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int NS_PER_CYCLE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [SEC_W-1:0]  tod_sec_o,
  output logic [NS_W-1:0]   tod_ns_o
);
  tod_t              live;
  logic [SEC_W-1:0]  sh_sec;
  logic [DATA_W-1:0] sh_ns;
  logic              do_load, do_delta;
  logic [IVL_W-1:0]  trim_ivl;
  logic              trim_unit, trim_en, trim_dir, trim_clr, trim_pulse;

  tod_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .live_i      (live),
    .sh_sec_o    (sh_sec),
    .sh_ns_o     (sh_ns),
    .do_load_o   (do_load),
    .do_delta_o  (do_delta),
    .trim_ivl_o  (trim_ivl),
    .trim_unit_o (trim_unit),
    .trim_en_o   (trim_en),
    .trim_dir_o  (trim_dir),
    .trim_clr_o  (trim_clr)
  );

  tod_trim #(.NS_PER_CYCLE(NS_PER_CYCLE)) u_trim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ivl_i   (trim_ivl),
    .unit_i  (trim_unit),
    .en_i    (trim_en),
    .clr_i   (trim_clr),
    .pulse_o (trim_pulse)
  );

  tod_counter #(.NS_PER_CYCLE(NS_PER_CYCLE)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (do_load),
    .delta_i      (do_delta),
    .sh_sec_i     (sh_sec),
    .sh_ns_i      (sh_ns),
    .trim_pulse_i (trim_pulse),
    .trim_dir_i   (trim_dir),
    .tod_o        (live)
  );

  assign tod_sec_o = live.sec;
  assign tod_ns_o  = live.ns;
endmodule

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [47:0] sec;
  logic [29:0] ns;

  int n_chk = 0;
  int n_fail = 0;
  longint pre_t;
  logic [47:0] pre_sec;
  logic [29:0] pre_ns;

  localparam longint NSPS = 64'd1_000_000_000;

  tod_clock u_tod_clock (
    .clk_i (clk), .rst_ni (rst_n), .bus_we_i (we), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .tod_sec_o (sec), .tod_ns_o (ns)
  );

  always #5 clk = ~clk;

  function automatic longint now_t();
    return longint'(sec) * NSPS + longint'(ns);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    pre_t = now_t(); pre_sec = sec; pre_ns = ns;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic load_time(input logic [47:0] s, input logic [31:0] n);
    wr(3'd0, 32'd0);
    wr(3'd1, {16'd0, s[47:32]});
    wr(3'd2, s[31:0]);
    wr(3'd3, n);
    wr(3'd0, 32'd2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sec in reset", longint'(sec), 0);
    chk("R1 ns in reset", longint'(ns), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 register read in reset", longint'(v), 0);
    end
  endtask

  task automatic t_free_run();
    longint t0;
    t0 = now_t();
    @(negedge clk);
    chk("R2 one cycle step", now_t() - t0, 8);
    t0 = now_t();
    repeat (10) @(negedge clk);
    chk("R2 ten cycle step", now_t() - t0, 80);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(3'd3, 32'd12345);
    chk("R5 shadow ns write ignored by live", now_t() - pre_t, 8);
    wr(3'd1, 32'd7);
    chk("R5 shadow hi write ignored by live", now_t() - pre_t, 8);
    wr(3'd0, 32'd0);
    chk("R5 IDLE leaves time running", now_t() - pre_t, 8);
    rd(3'd0, v);
    chk("R5 action readback IDLE", longint'(v), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd4, 32'hC000_0055);
    rd(3'd4, v);
    chk("R4 trim interval readback", longint'(v), longint'(32'h4000_0055));
    wr(3'd5, 32'hFFFF_FFFC);
    rd(3'd5, v);
    chk("R4 trim ctrl readback", longint'(v), 0);
    wr(3'd1, 32'hABCD_1234);
    rd(3'd1, v);
    chk("R4 shadow hi readback", longint'(v), longint'(32'h0000_1234));
    wr(3'd2, 32'hDEAD_BEEF);
    rd(3'd2, v);
    chk("R4 shadow lo readback", longint'(v), longint'(32'hDEAD_BEEF));
    wr(3'd3, 32'h8765_4321);
    rd(3'd3, v);
    chk("R4 shadow ns readback", longint'(v), longint'(32'h8765_4321));
    wr(3'd4, 32'd0);
  endtask

  task automatic t_load_roll();
    logic [31:0] v;
    load_time(48'h0000_FFFF_FFFF, 32'd999_999_995);
    chk("R7 load sec", longint'(sec), longint'(48'h0000_FFFF_FFFF));
    chk("R7 load ns", longint'(ns), 999_999_995);
    @(negedge clk);
    chk("R3 carry into sec upper word", longint'(sec), longint'(48'h0001_0000_0000));
    chk("R3 ns wrap", longint'(ns), 3);
    wr(3'd0, 32'd1);
    rd(3'd1, v);
    chk("R6 save sec hi", longint'(v), longint'(pre_sec[47:32]));
    rd(3'd2, v);
    chk("R6 save sec lo", longint'(v), longint'(pre_sec[31:0]));
    rd(3'd3, v);
    chk("R6 save ns", longint'(v), longint'(pre_ns));
    rd(3'd0, v);
    chk("R4 action readback SAVE", longint'(v), 1);
  endtask

  task automatic t_neg_load();
    load_time(48'd20, 32'h3FFF_FFF5);
    chk("R8 negative ns sec", longint'(sec), 19);
    chk("R8 negative ns value", longint'(ns), 999_999_989);
    load_time(48'd20, 32'd1_000_000_000);
    chk("R8 clamp sec", longint'(sec), 20);
    chk("R8 clamp ns", longint'(ns), 999_999_999);
    load_time(48'd20, 32'h3FFF_FFEF);
    chk("R8 below window clamps", longint'(ns), 999_999_999);
  endtask

  task automatic t_delta();
    load_time(48'd100, 32'd100);
    wr(3'd3, 32'hFFFF_FF38);
    wr(3'd0, 32'd3);
    chk("R9 negative delta total", now_t() - pre_t, 8 - 200);
    chk("R9 negative delta borrow sec", longint'(sec), 99);
    load_time(48'd50, 32'd999_999_800);
    wr(3'd3, 32'd300);
    wr(3'd0, 32'd3);
    chk("R9 positive delta total", now_t() - pre_t, 308);
    chk("R9 positive delta carry sec", longint'(sec), 51);
    wr(3'd3, 32'h8000_0001);
    wr(3'd0, 32'd3);
    chk("R9 negative saturation", now_t() - pre_t, 8 - 499_999_999);
    wr(3'd3, 32'h7FFF_FFF0);
    wr(3'd0, 32'd3);
    chk("R9 positive saturation", now_t() - pre_t, 8 + 499_999_999);
  endtask

  task automatic window(input string req, input longint exp);
    longint t0;
    repeat (3) @(negedge clk);
    t0 = now_t();
    repeat (50) @(negedge clk);
    chk(req, now_t() - t0, exp);
  endtask

  task automatic t_trim();
    wr(3'd4, 32'h4000_0028);
    wr(3'd5, 32'd1);
    window("R10 ns unit speed up", 410);
    wr(3'd4, 32'd40_000);
    wr(3'd5, 32'd3);
    window("R10 ps unit slow down", 390);
    wr(3'd4, 32'h4000_0008);
    wr(3'd5, 32'd1);
    window("R10 interval at step every cycle", 450);
    wr(3'd5, 32'd0);
    window("R11 trim disabled", 400);
    wr(3'd5, 32'd2);
    window("R11 direction without enable", 400);
  endtask

  initial begin
    #2;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_free_run();
    t_ignored();
    t_regs();
    t_load_roll();
    t_neg_load();
    t_delta();
    t_trim();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule